// File: doc/BRIEF.md
# Asynchronous SRAM Interface Controller

This block sits between a clocked host and an external asynchronous static RAM of 24-bit words at 17-bit addresses. The host offers one word at a time through a request/ready handshake carrying an address, write data and a write flag. Read results come back on a data port qualified by a one-clock valid strobe. On the memory side the controller drives the address, an active-low and an active-high chip select, an active-low write strobe, an active-low output enable, and a bidirectional data bus split into an outgoing word, an incoming word and a drive enable.

All memory timing is derived from picosecond parameters and one clock-period parameter. Each minimum is rounded up to whole clock cycles, with a floor of one cycle. The output enable stays high for the whole of every write. The controller's data driver switches on only after a guard interval that covers the memory's output turn-off time after the write strobe falls. It switches off on the same clock edge that ends the write. All memory-side outputs come straight from flops.

Top module: `asram_ctrl`

## Requirements
- R1: After reset, `ready` is 1, `rd_valid` is 0, `mem_ce_n` is 1, `mem_ce` is 0, `mem_we_n` is 1, `mem_oe_n` is 1 and `mem_dq_oe` is 0.
- R2: `mem_we_n` is low only while the memory is selected (`mem_ce_n` = 0 and `mem_ce` = 1).
- R3: A write holds `mem_we_n` low for WL cycles. WL is the largest of ceil(PWE_PS/CLK_PS), ceil(AWE_PS/CLK_PS) and ceil(WZ_PS/CLK_PS)+ceil(DS_PS/CLK_PS). `mem_oe_n` stays 1 throughout.
- R4: In a write, `mem_dq_oe` is 0 for the first ceil(WZ_PS/CLK_PS) strobe-low cycles. It is 1 for the remaining strobe-low cycles and is never 1 while `mem_we_n` is 1. `mem_dq_out` carries the accepted write data and `mem_addr` the accepted address.
- R5: A read holds `mem_we_n` high and `mem_oe_n` low, with the memory selected, for RD = ceil(AA_PS/CLK_PS) cycles. `mem_dq_in` is captured at the end of the last of these cycles. `rd_valid` is 1 for exactly the following clock, with `rd_data` holding the captured word.
- R6: `ready` falls on the edge that accepts a request (`req` and `ready` both 1). It stays low for T cycles: for a write, T is the larger of ceil(WC_PS/CLK_PS) and WL+1; for a read, T is the larger of ceil(WC_PS/CLK_PS) and RD+1.
- R7: A request presented while `ready` is 0 is ignored: `mem_addr` keeps the accepted address and no further memory access follows.
- R8: A read returns the word most recently written to the same address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Host request |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Word address |
| req_wdata | input | 24 | Write data |
| ready | output | 1 | Controller can accept a request |
| rd_valid | output | 1 | One-clock strobe for read data |
| rd_data | output | 24 | Read data |
| mem_addr | output | 17 | Memory address |
| mem_ce_n | output | 1 | Active-low chip select |
| mem_ce | output | 1 | Active-high chip select |
| mem_we_n | output | 1 | Active-low write strobe |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_dq_out | output | 24 | Data driven toward the memory |
| mem_dq_oe | output | 1 | Drive enable for mem_dq_out |
| mem_dq_in | input | 24 | Data seen on the memory bus |

## Verification
The bench runs at a 5000 ps clock with the default write timing and raises AA_PS to 15000. This gives a two-cycle write strobe, a one-cycle guard, a one-cycle data setup, a three-cycle read, and cycle lengths of three for a write and four for a read. With these values the guard cycle appears separately from the driven cycle, and reads and writes differ in length. Back-to-back mixed traffic therefore tests both the ready timing and the turnaround between the two operations. Boundary addresses, all-zero and all-one words, and requests held during a busy cycle are covered, with a bus model that reports contention.

// File: rtl/asram_ctrl.sv
module asram_ctrl #(
  parameter int AW     = 17,
  parameter int DW     = 24,
  parameter int CLK_PS = 5000,
  parameter int WC_PS  = 10000,
  parameter int AWE_PS = 8000,
  parameter int PWE_PS = 8000,
  parameter int DS_PS  = 5000,
  parameter int WZ_PS  = 3500,
  parameter int AA_PS  = 10000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic          req_wr,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          ready,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data,
  output logic [AW-1:0] mem_addr,
  output logic          mem_ce_n,
  output logic          mem_ce,
  output logic          mem_we_n,
  output logic          mem_oe_n,
  output logic [DW-1:0] mem_dq_out,
  output logic          mem_dq_oe,
  input  logic [DW-1:0] mem_dq_in
);

  function automatic int cyc(input int ps);
    int c;
    c = (ps + CLK_PS - 1) / CLK_PS;
    return (c < 1) ? 1 : c;
  endfunction

  localparam int PWE_C  = cyc(PWE_PS);
  localparam int ASU_C  = cyc(AWE_PS);
  localparam int GRD_C  = cyc(WZ_PS);
  localparam int DS_C   = cyc(DS_PS);
  localparam int WC_C   = cyc(WC_PS);
  localparam int RD_C   = cyc(AA_PS);
  localparam int W1_C   = (PWE_C > ASU_C) ? PWE_C : ASU_C;
  localparam int WL_C   = (W1_C > GRD_C + DS_C) ? W1_C : GRD_C + DS_C;
  localparam int TW_C   = (WC_C > WL_C) ? WC_C : WL_C + 1;
  localparam int TR_C   = (WC_C > RD_C) ? WC_C : RD_C + 1;
  localparam int TMAX_C = (TW_C > TR_C) ? TW_C : TR_C;
  localparam int CW     = $clog2(TMAX_C + 1);

  localparam logic [CW-1:0] WL_V    = CW'(WL_C);
  localparam logic [CW-1:0] RD_V    = CW'(RD_C);
  localparam logic [CW-1:0] GRD_V   = CW'(GRD_C);
  localparam logic [CW-1:0] TW_LAST = CW'(TW_C - 1);
  localparam logic [CW-1:0] TR_LAST = CW'(TR_C - 1);
  localparam logic [CW-1:0] RD_LAST = CW'(RD_C - 1);

  logic          busy, op_wr;
  logic [CW-1:0] cnt;
  logic          busy_nx, wr_nx, act_nx;
  logic [CW-1:0] cnt_nx;

  assign ready = !busy;

  always_comb begin
    busy_nx = busy;
    wr_nx   = op_wr;
    cnt_nx  = cnt;
    if (!busy) begin
      cnt_nx = '0;
      if (req) begin
        busy_nx = 1'b1;
        wr_nx   = req_wr;
      end
    end else if (cnt == (op_wr ? TW_LAST : TR_LAST)) begin
      busy_nx = 1'b0;
      cnt_nx  = '0;
    end else begin
      cnt_nx = cnt + 1'b1;
    end
    act_nx = busy_nx && (cnt_nx < (wr_nx ? WL_V : RD_V));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy       <= 1'b0;
      op_wr      <= 1'b0;
      cnt        <= '0;
      mem_addr   <= '0;
      mem_dq_out <= '0;
      mem_ce_n   <= 1'b1;
      mem_ce     <= 1'b0;
      mem_we_n   <= 1'b1;
      mem_oe_n   <= 1'b1;
      mem_dq_oe  <= 1'b0;
      rd_valid   <= 1'b0;
      rd_data    <= '0;
    end else begin
      busy  <= busy_nx;
      op_wr <= wr_nx;
      cnt   <= cnt_nx;
      if (!busy && req) begin
        mem_addr   <= req_addr;
        mem_dq_out <= req_wdata;
      end
      mem_ce_n  <= !act_nx;
      mem_ce    <= act_nx;
      mem_we_n  <= !(act_nx && wr_nx);
      mem_oe_n  <= !(act_nx && !wr_nx);
      mem_dq_oe <= act_nx && wr_nx && (cnt_nx >= GRD_V);
      rd_valid  <= busy && !op_wr && (cnt == RD_LAST);
      if (busy && !op_wr && (cnt == RD_LAST))
        rd_data <= mem_dq_in;
    end
  end

endmodule

module asram_ctrl_chk #(
  parameter int CLK_PS = 5000,
  parameter int WC_PS  = 10000,
  parameter int AWE_PS = 8000,
  parameter int PWE_PS = 8000,
  parameter int DS_PS  = 5000
) (
  input logic clk,
  input logic rst_n,
  input logic req,
  input logic ready,
  input logic rd_valid,
  input logic mem_ce_n,
  input logic mem_ce,
  input logic mem_we_n,
  input logic mem_oe_n,
  input logic mem_dq_oe
);

  function automatic int cyc(input int ps);
    int c;
    c = (ps + CLK_PS - 1) / CLK_PS;
    return (c < 1) ? 1 : c;
  endfunction

  localparam int PWE_C = cyc(PWE_PS);
  localparam int ASU_C = cyc(AWE_PS);
  localparam int DS_C  = cyc(DS_PS);
  localparam int WC_C  = cyc(WC_PS);

  int we_run, dq_run, since_acc;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      we_run    <= 0;
      dq_run    <= 0;
      since_acc <= WC_C;
    end else begin
      we_run <= mem_we_n ? 0 : we_run + 1;
      dq_run <= mem_dq_oe ? dq_run + 1 : 0;
      if (req && ready) since_acc <= 1;
      else if (since_acc < WC_C) since_acc <= since_acc + 1;
    end
  end

  a_r2_we_needs_select: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (!mem_ce_n && mem_ce));
  a_r3_oe_off_in_write: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> mem_oe_n);
  a_r3_we_width: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (we_run >= PWE_C && we_run >= ASU_C));
  a_r4_data_setup: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> dq_run >= DS_C);
  a_r4_drive_in_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> (!mem_we_n && mem_oe_n));
  a_r4_guard: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_we_n) |-> !mem_dq_oe);
  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_dq_oe) |-> mem_we_n);
  a_r5_oe_read_only: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> (mem_we_n && !mem_ce_n));
  a_r5_valid_once: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);
  a_r6_min_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (req && ready) |-> since_acc >= WC_C);

endmodule

bind asram_ctrl asram_ctrl_chk #(
  .CLK_PS(CLK_PS), .WC_PS(WC_PS), .AWE_PS(AWE_PS), .PWE_PS(PWE_PS), .DS_PS(DS_PS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req(req), .ready(ready), .rd_valid(rd_valid),
  .mem_ce_n(mem_ce_n), .mem_ce(mem_ce), .mem_we_n(mem_we_n),
  .mem_oe_n(mem_oe_n), .mem_dq_oe(mem_dq_oe)
);

// File: tb/asram_ctrl_tb_top.sv
`timescale 1ns/1ps
module asram_ctrl_tb_top;
  // 5000 ps clock: WL=2, guard=1, RD=3 (AA_PS=15000), T write=3, T read=4
  localparam int WL = 2, GRD = 1, RD = 3, TW = 3, TR = 4;

  logic clk = 0, rst_n = 0;
  logic req = 0, req_wr = 0;
  logic [16:0] req_addr = '0;
  logic [23:0] req_wdata = '0;
  logic ready, rd_valid;
  logic [23:0] rd_data;
  logic [16:0] mem_addr;
  logic mem_ce_n, mem_ce, mem_we_n, mem_oe_n, mem_dq_oe;
  logic [23:0] mem_dq_out, mem_dq_in;

  always #2.5 clk = ~clk;

  asram_ctrl #(.AA_PS(15000)) dut_i (
    .clk(clk), .rst_n(rst_n), .req(req), .req_wr(req_wr), .req_addr(req_addr),
    .req_wdata(req_wdata), .ready(ready), .rd_valid(rd_valid), .rd_data(rd_data),
    .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_ce(mem_ce), .mem_we_n(mem_we_n),
    .mem_oe_n(mem_oe_n), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
    .mem_dq_in(mem_dq_in));

  int tests = 0, fails = 0;
  logic [23:0] mem [int];
  logic [23:0] shadow [int];
  logic [23:0] exp_q [$];
  logic [23:0] mdat = '0;
  wire sel = !mem_ce_n && mem_ce;
  wire mdrv = sel && !mem_oe_n && mem_we_n;
  assign mem_dq_in = mem_dq_oe ? mem_dq_out : (mdrv ? mdat : 24'h0);

  task automatic chk(input bit ok, input string r, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", r, act, exp, $time);
    end
  endtask

  // memory model, bus monitor and scoreboard
  int we_low = 0, since = 100;
  always @(negedge clk) if (rst_n) begin
    if (sel && !mem_we_n && mem_dq_oe) mem[int'(mem_addr)] = mem_dq_out;
    mdat = mem.exists(int'(mem_addr)) ? mem[int'(mem_addr)] : 24'h0;
    chk(!(mem_dq_oe && mdrv), "R4 contention", {30'd0, mem_dq_oe, mdrv}, 0);
    if (!mem_we_n) chk(sel, "R2 select", {31'd0, sel}, 1);
    if (!mem_we_n) we_low++;
    else if (we_low != 0) begin
      chk(we_low == WL, "R3 strobe width", we_low, WL);
      we_low = 0;
    end
    if (rd_valid) begin
      if (exp_q.size() == 0) chk(0, "R5 unexpected rd_valid", rd_data, 0);
      else begin
        logic [23:0] e;
        e = exp_q.pop_front();
        chk(rd_data == e, "R8 read data", rd_data, e);
      end
    end
    since++;
    if (req && ready) begin
      chk(since >= TW, "R6 accept spacing", since, TW);
      since = 0;
    end
  end

  task automatic issue(input bit wr, input logic [16:0] a, input logic [23:0] d);
    while (!ready) @(negedge clk);
    req = 1; req_wr = wr; req_addr = a; req_wdata = d;
    if (wr) shadow[int'(a)] = d;
    else exp_q.push_back(shadow.exists(int'(a)) ? shadow[int'(a)] : 24'h0);
    @(posedge clk); #1 req = 0;
  endtask

  task automatic trace_wr(input logic [16:0] a, input logic [23:0] d);
    @(negedge clk); issue(1, a, d);
    for (int k = 1; k <= TW + 1; k++) begin
      @(negedge clk);
      chk(mem_we_n == !(k <= WL), "R3 we_n", mem_we_n, !(k <= WL));
      chk(mem_oe_n == 1, "R3 oe_n in write", mem_oe_n, 1);
      chk(mem_dq_oe == (k > GRD && k <= WL), "R4 dq_oe", mem_dq_oe, (k > GRD && k <= WL));
      chk(ready == (k > TW), "R6 ready write", ready, (k > TW));
      if (k <= WL) chk(mem_addr == a, "R4 addr", mem_addr, a);
      if (mem_dq_oe) chk(mem_dq_out == d, "R4 data", mem_dq_out, d);
    end
  endtask

  task automatic trace_rd(input logic [16:0] a);
    @(negedge clk); issue(0, a, 0);
    for (int k = 1; k <= TR + 1; k++) begin
      @(negedge clk);
      chk(mem_oe_n == !(k <= RD), "R5 oe_n", mem_oe_n, !(k <= RD));
      chk(mem_we_n == 1, "R5 we_n", mem_we_n, 1);
      chk(mem_ce_n == !(k <= RD), "R5 ce_n", mem_ce_n, !(k <= RD));
      chk(rd_valid == (k == RD + 1), "R5 rd_valid", rd_valid, (k == RD + 1));
      chk(ready == (k > TR), "R6 ready read", ready, (k > TR));
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(ready == 1 && rd_valid == 0, "R1 host side", {ready, rd_valid}, 2'b10);
    chk(mem_ce_n == 1 && mem_ce == 0, "R1 selects", {mem_ce_n, mem_ce}, 2'b10);
    chk(mem_we_n == 1 && mem_oe_n == 1 && mem_dq_oe == 0, "R1 strobes",
        {mem_we_n, mem_oe_n, mem_dq_oe}, 3'b110);
    rst_n = 1;
    trace_wr(17'h00000, 24'hFFFFFF);
    trace_wr(17'h1FFFF, 24'hA5C3E1);
    trace_rd(17'h00000);
    trace_rd(17'h1FFFF);
    trace_wr(17'h00000, 24'h000000);
    trace_rd(17'h00000);
    // R7: request held while busy must be ignored
    @(negedge clk); issue(1, 17'h00123, 24'h123456);
    req = 1; req_wr = 1; req_addr = 17'h00456; req_wdata = 24'hBADBAD;
    @(posedge clk); @(posedge clk); #1 req = 0;
    @(negedge clk);
    chk(mem_addr == 17'h00123, "R7 addr held", mem_addr, 17'h00123);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(mem_ce_n == 1, "R7 no extra access", mem_ce_n, 1);
    end
    @(negedge clk); issue(0, 17'h00456, 0);
    issue(0, 17'h00123, 0);
    // R8: back-to-back mixed traffic
    for (int i = 0; i < 60; i++) begin
      logic [16:0] a;
      a = {$urandom_range(0, 1) ? 4'hF : 4'h0, 9'd0, 4'($urandom_range(0, 15))};
      if (i > 1) @(negedge clk);
      issue(1'($urandom_range(0, 1)), a, 24'($urandom));
    end
    for (int i = 0; i < 16; i++) begin
      @(negedge clk); issue(0, {4'hF, 9'd0, 4'(i)}, 0);
    end
    repeat (10) @(negedge clk);
    chk(exp_q.size() == 0, "R5 all reads returned", exp_q.size(), 0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule